// File: doc/BRIEF.md
# Processor Initialization Pulse Generator

This block drives the active-low processor initialization line from several reset sources. Software-requested initialization events come from elsewhere in the chip as single-cycle request strobes. A reset request from the external keyboard controller arrives as an asynchronous active-low pin, and a PCI bus reset pin may also drive the line. Every request from software or from the keyboard controller produces an initialization pulse of a fixed number of PCI clocks (16 by default). The pulse comes from a registered output, so it is free of glitches and synchronous to the PCI clock.

The keyboard-controller pin is synchronized and only its falling edge starts a pulse, so a pin that stays low produces one pulse. An edge that arrives while the chip is entering a sleep state is dropped. When built-in self-test support is configured, the line is held active for as long as the PCI reset pin is low, and it is released on the clock after the pin returns high. The block also merges the keyboard controller's A20 gate pin with the chip's internal A20 mask source to drive the active-low address-bit-20 mask output.

Top module: `cpu_init_pulse_gen`

## Requirements
- R1: While `rst_n` is sampled low, `init_n` is driven high (inactive) from the next clock edge. The pulse counter and the keyboard-pin synchronizer are cleared, so no pulse follows the release of reset.
- R2: A high level on any bit of `sw_init_req` at a rising clock edge drives `init_n` low from that edge. `init_n` then stays low for exactly PULSE_CLKS (16) clock cycles.
- R3: A falling edge on `kbd_rst_n` passes through two synchronizer flops. It drives `init_n` low from the third rising edge after the pin falls, for exactly PULSE_CLKS cycles.
- R4: If `kbd_rst_n` stays low for any length of time, it produces only one pulse. A new pulse needs the pin to return high and fall again.
- R5: A keyboard falling edge that is detected while `sleep_entry` is high is discarded. No pulse follows, even after `sleep_entry` drops while the pin is still low.
- R6: A new request from any source that arrives during an active pulse reloads the count. `init_n` then stays low for PULSE_CLKS cycles counted from the new request.
- R7: With `bist_cfg` high, `init_n` is low from the edge after `pci_rst_n` is sampled low. It stays low as long as the pin is low, and goes high on the first edge at which the pin is sampled high, provided no pulse count remains.
- R8: With `bist_cfg` low, `pci_rst_n` has no effect on `init_n`.
- R9: `a20m_n` is low whenever `kbd_a20_gate` or `a20_mask_int` is high. It is high only when both are low. The path is combinational and has no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sw_init_req | input | SRC_COUNT | Internal initialization request strobes, active high, one bit per source |
| kbd_rst_n | input | 1 | Keyboard-controller reset request pin, asynchronous, active low |
| sleep_entry | input | 1 | High while the chip is entering a low-power state |
| pci_rst_n | input | 1 | PCI bus reset, active low, synchronous to clk |
| bist_cfg | input | 1 | Static configuration: PCI reset also holds the initialization line active |
| kbd_a20_gate | input | 1 | A20 gate pin from the keyboard controller, active high |
| a20_mask_int | input | 1 | Internal A20 mask source, active high |
| init_n | output | 1 | Processor initialization output, active low, registered |
| a20m_n | output | 1 | Address-bit-20 mask output, active low |

## Verification
Each fault in the pulse counter shows up within a single pulse, because the number of low cycles on `init_n` comes out shorter or longer than 16. A counter that is not reloaded on a retrigger ends the line 16 cycles after the first request instead of the second. A fault in the synchronizer or the edge detector moves the start of a pulse by one or more cycles, repeats the pulse while the pin stays low, or lets an edge through during sleep entry. All of these are visible on `init_n` within about twenty cycles of the stimulus. A fault in the self-test hold shows as `init_n` failing to follow `pci_rst_n` on the next edge, and a fault in the A20 merge shows at once on `a20m_n`.

// File: rtl/cpu_init_pkg.sv
// Package: shared defaults and the request bundle for the initialization
// pulse generator. Assumes nothing beyond a single PCI clock domain.
package cpu_init_pkg;

    // Default pulse length in PCI clocks.
    localparam int unsigned DEF_PULSE_CLKS = 16;
    // Default number of synchronizer flops for the keyboard reset pin.
    localparam int unsigned DEF_SYNC_STAGES = 2;

    // Qualified requests feeding the pulse stretcher.
    typedef struct packed {
        logic kbd;   // keyboard falling edge, not masked by sleep entry
        logic sw;    // any software request bit
    } init_req_t;

endpackage

// File: rtl/kbd_reset_edge.sv
// Module: kbd_reset_edge
// Brings the asynchronous active-low keyboard reset pin into the clock
// domain through SYNC_STAGES flops. It flags a single-cycle request on each
// falling edge, unless sleep entry is in progress.
// Assumes: synchronous active-low reset, idle pin level is high.
module kbd_reset_edge #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    input  logic sleep_entry,
    output logic req
);
    localparam int unsigned CHAIN_W = SYNC_STAGES + 1;

    logic [CHAIN_W-1:0] chain;

    // Synchronizer shift chain plus one history flop for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[CHAIN_W-2:0], pin_n};
    end

    // Falling edge: previous synchronized level high, current level low.
    assign req = chain[CHAIN_W-1] & ~chain[CHAIN_W-2] & ~sleep_entry;

endmodule

// File: rtl/init_stretch.sv
// Module: init_stretch
// Turns single-cycle requests into an active-low pulse of PULSE_CLKS clocks.
// A request during a pulse reloads the count. A level hold input keeps the
// output active for as long as it is high.
// Assumes: trig and hold are synchronous to clk.
module init_stretch #(
    parameter int unsigned PULSE_CLKS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    input  logic hold,
    output logic init_n
);
    localparam int unsigned CNT_W = $clog2(PULSE_CLKS + 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;

    // Next count: reload on request, otherwise count down to zero.
    always_comb begin
        if (trig)            cnt_d = CNT_W'(PULSE_CLKS);
        else if (cnt_q != 0) cnt_d = cnt_q - 1'b1;
        else                 cnt_d = '0;
    end

    // Count register and registered active-low output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            init_n <= 1'b1;
        end else begin
            cnt_q  <= cnt_d;
            init_n <= ~((cnt_d != 0) | hold);
        end
    end

endmodule

// File: rtl/a20_merge.sv
// Module: a20_merge
// Combines the keyboard A20 gate pin with the internal A20 mask source into
// the active-low mask output. Purely combinational.
module a20_merge (
    input  logic gate_in,
    input  logic mask_int,
    output logic mask_n
);
    // Either source forces the mask active.
    assign mask_n = ~(gate_in | mask_int);

endmodule

// File: rtl/cpu_init_pulse_gen.sv
// Module: cpu_init_pulse_gen (top)
// Merges software, keyboard-controller and (optionally) PCI reset sources
// into one registered active-low processor initialization line. It also
// drives the A20 mask output.
// Assumes: clk is the PCI clock, reset is synchronous active low,
// sw_init_req and pci_rst_n are synchronous to clk, and kbd_rst_n is not.
module cpu_init_pulse_gen #(
    parameter int unsigned SRC_COUNT   = 2,
    parameter int unsigned PULSE_CLKS  = cpu_init_pkg::DEF_PULSE_CLKS,
    parameter int unsigned SYNC_STAGES = cpu_init_pkg::DEF_SYNC_STAGES
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [SRC_COUNT-1:0] sw_init_req,
    input  logic                 kbd_rst_n,
    input  logic                 sleep_entry,
    input  logic                 pci_rst_n,
    input  logic                 bist_cfg,
    input  logic                 kbd_a20_gate,
    input  logic                 a20_mask_int,
    output logic                 init_n,
    output logic                 a20m_n
);
    import cpu_init_pkg::*;

    init_req_t req;
    logic      bist_hold;

    // Keyboard pin synchronizer and sleep-qualified edge detector.
    kbd_reset_edge #(.SYNC_STAGES(SYNC_STAGES)) u_kbd_edge (
        .clk         (clk),
        .rst_n       (rst_n),
        .pin_n       (kbd_rst_n),
        .sleep_entry (sleep_entry),
        .req         (req.kbd)
    );

    // Any software source requests a pulse.
    assign req.sw    = |sw_init_req;
    // PCI reset holds the line only when self-test support is configured.
    assign bist_hold = bist_cfg & ~pci_rst_n;

    // Pulse stretcher and output register.
    init_stretch #(.PULSE_CLKS(PULSE_CLKS)) u_stretch (
        .clk    (clk),
        .rst_n  (rst_n),
        .trig   (req.sw | req.kbd),
        .hold   (bist_hold),
        .init_n (init_n)
    );

    // A20 mask merge.
    a20_merge u_a20 (
        .gate_in  (kbd_a20_gate),
        .mask_int (a20_mask_int),
        .mask_n   (a20m_n)
    );

endmodule

// File: rtl/cpu_init_pulse_gen_chk.sv
// Module: cpu_init_pulse_gen_chk
// Property checker bound to cpu_init_pulse_gen. It watches the ports only.
// A local counter tracks the minimum pulse window after a software request.
module cpu_init_pulse_gen_chk #(
    parameter int unsigned SRC_COUNT  = 2,
    parameter int unsigned PULSE_CLKS = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [SRC_COUNT-1:0] sw_init_req,
    input logic                 pci_rst_n,
    input logic                 bist_cfg,
    input logic                 kbd_a20_gate,
    input logic                 a20_mask_int,
    input logic                 init_n,
    input logic                 a20m_n
);
    localparam int unsigned CNT_W = $clog2(PULSE_CLKS + 1);

    logic [CNT_W-1:0] win_q;

    // Cycles remaining in which a software-started pulse must still be low.
    always_ff @(posedge clk) begin
        if (!rst_n)               win_q <= '0;
        else if (|sw_init_req)    win_q <= CNT_W'(PULSE_CLKS);
        else if (win_q != 0)      win_q <= win_q - 1'b1;
    end

    // R1: reset forces the line inactive on the next edge.
    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> init_n);

    // R2: a software request drives the line low on the next sample.
    assert_sw_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (|sw_init_req) |=> !init_n);

    // R2, R6: the line stays low for the whole window after the latest request.
    assert_min_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (win_q != 0) |-> !init_n);

    // R7: PCI reset with self-test support holds the line low.
    assert_bist_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bist_cfg && !pci_rst_n) |=> !init_n);

    // R9: either A20 source forces the mask active.
    assert_a20_force_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (kbd_a20_gate || a20_mask_int) |-> !a20m_n);

endmodule

bind cpu_init_pulse_gen cpu_init_pulse_gen_chk #(
    .SRC_COUNT  (SRC_COUNT),
    .PULSE_CLKS (PULSE_CLKS)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sw_init_req  (sw_init_req),
    .pci_rst_n    (pci_rst_n),
    .bist_cfg     (bist_cfg),
    .kbd_a20_gate (kbd_a20_gate),
    .a20_mask_int (a20_mask_int),
    .init_n       (init_n),
    .a20m_n       (a20m_n)
);

// File: tb/cpu_init_pulse_gen_bench.sv
// Bench for cpu_init_pulse_gen: an A20 vector table walked by one loop,
// then directed tests of the pulse sources and corner cases.
// Inputs change on the falling clock edge and outputs are sampled there.
module cpu_init_pulse_gen_bench;
    localparam int CLK_PERIOD = 10;
    localparam int SRC_COUNT  = 2;
    localparam int PULSE      = 16;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [SRC_COUNT-1:0] sw_init_req = '0;
    logic                 kbd_rst_n = 1'b1;
    logic                 sleep_entry = 1'b0;
    logic                 pci_rst_n = 1'b1;
    logic                 bist_cfg = 1'b0;
    logic                 kbd_a20_gate = 1'b0;
    logic                 a20_mask_int = 1'b0;
    logic                 init_n;
    logic                 a20m_n;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    // Vector table: {gate, internal, expected a20m_n}.
    localparam logic [2:0] A20_VEC [4] = '{3'b001, 3'b010, 3'b100, 3'b110};

    always #(CLK_PERIOD/2) clk = ~clk;

    cpu_init_pulse_gen #(.SRC_COUNT(SRC_COUNT), .PULSE_CLKS(PULSE)) u_cpu_init_pulse_gen (
        .clk          (clk),
        .rst_n        (rst_n),
        .sw_init_req  (sw_init_req),
        .kbd_rst_n    (kbd_rst_n),
        .sleep_entry  (sleep_entry),
        .pci_rst_n    (pci_rst_n),
        .bist_cfg     (bist_cfg),
        .kbd_a20_gate (kbd_a20_gate),
        .a20_mask_int (a20_mask_int),
        .init_n       (init_n),
        .a20m_n       (a20m_n)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Samples now, then advances one falling edge, n times; returns low count.
    task automatic count_low(input int n, output int lows);
        lows = 0;
        for (int i = 0; i < n; i++) begin
            if (!init_n) lows++;
            @(negedge clk);
        end
    endtask

    // One-cycle software request on bit idx.
    task automatic pulse_sw(input int idx);
        sw_init_req[idx] = 1'b1;
        @(negedge clk);
        sw_init_req = '0;
    endtask

    initial begin
        int lows;
        repeat (3) @(negedge clk);
        check("R1 init_n in reset", int'(init_n), 1);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 init_n after reset", int'(init_n), 1);

        // R9: A20 merge, vector table.
        for (int v = 0; v < 4; v++) begin
            kbd_a20_gate = A20_VEC[v][2];
            a20_mask_int = A20_VEC[v][1];
            #1;
            check("R9 a20m_n", int'(a20m_n), int'(A20_VEC[v][0]));
        end
        kbd_a20_gate = 1'b0;
        a20_mask_int = 1'b0;
        @(negedge clk);

        // R2: each software bit gives a 16-cycle pulse.
        pulse_sw(0);
        count_low(40, lows);
        check("R2 sw bit0 pulse length", lows, PULSE);
        pulse_sw(1);
        count_low(40, lows);
        check("R2 sw bit1 pulse length", lows, PULSE);

        // R6: retrigger after 5 low cycles reloads the count.
        pulse_sw(0);
        count_low(5, lows);
        check("R6 first segment low", lows, 5);
        pulse_sw(1);
        count_low(40, lows);
        check("R6 reloaded pulse length", lows, PULSE);

        // R3, R4: keyboard pin held low gives one pulse starting on the 3rd edge.
        kbd_rst_n = 1'b0;
        count_low(3, lows);
        check("R3 kbd pulse latency", lows, 0);
        count_low(40, lows);
        check("R4 kbd held low single pulse", lows, PULSE);
        kbd_rst_n = 1'b1;
        count_low(5, lows);

        // R5: edge during sleep entry is discarded, also after sleep drops.
        sleep_entry = 1'b1;
        kbd_rst_n   = 1'b0;
        count_low(10, lows);
        check("R5 kbd masked during sleep", lows, 0);
        sleep_entry = 1'b0;
        count_low(30, lows);
        check("R5 no late pulse after sleep", lows, 0);
        kbd_rst_n = 1'b1;
        count_low(5, lows);
        kbd_rst_n = 1'b0;
        count_low(40, lows);
        check("R3 kbd pulse after sleep", lows, PULSE);
        kbd_rst_n = 1'b1;
        count_low(5, lows);

        // R7: PCI reset with self-test support holds the line.
        bist_cfg  = 1'b1;
        pci_rst_n = 1'b0;
        count_low(30, lows);
        check("R7 held during pci reset", lows, 29);
        check("R7 still low before release", int'(init_n), 0);
        pci_rst_n = 1'b1;
        @(negedge clk);
        check("R7 release next clock", int'(init_n), 1);

        // R8: without self-test support PCI reset has no effect.
        bist_cfg  = 1'b0;
        pci_rst_n = 1'b0;
        count_low(20, lows);
        check("R8 pci reset ignored", lows, 0);
        pci_rst_n = 1'b1;

        // R1: reset in mid-pulse clears the count.
        pulse_sw(0);
        count_low(3, lows);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset ends pulse", int'(init_n), 1);
        rst_n = 1'b1;
        count_low(20, lows);
        check("R1 no pulse after reset", lows, 0);

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule